// File: doc/BRIEF.md
# Four-Channel Serial DAC Command Front End

This block is the digital side of a four-channel, 8-bit digital-to-analog converter. A host talks to it over a serial port made of a clock, an active-low select, a data input and a data output. Each transfer is a 12-bit word, most significant bit first: a 2-bit channel address, a 2-bit control code, then an 8-bit code. The word is decoded when the select line returns high. The block holds one staging register and one output register per channel, so channels can be preloaded one at a time and then switched together.

Commands can load a staging register alone, load a staging register and its output register together, load the same code into all four output registers, copy every staging register into its output register, or change the edge on which the data output moves. An active-low clear input zeroes all eight registers. An active-low load input copies staging into output registers for as long as it is held low. The data output repeats each received bit twelve serial clocks later, so several blocks can be chained on one select line. All serial and control pins are sampled by a system clock that runs at least four times faster than the serial clock.

Top module: `qdac_front`

## Requirements
- R1: A bit on `sdi_i` is taken in on each rising edge of `sclk_i` while `csn_i` is low. After 12 bits the word holds, from oldest to newest: address bits [11:10] (channel 0 to 3), control bits [9:8], and code bits [7:0].
- R2: When more than 12 bits arrive in one select-low window, only the last 12 received are decoded. Bits received earlier are dropped.
- R3: A command takes effect only when `csn_i` rises, and the output registers show it within 6 system clocks. While `csn_i` is high, `sclk_i` edges do not shift data and `sdo_o` keeps its level.
- R4: `sdo_o` presents each received bit 12 serial clocks after it was taken in. In rising mode it changes on the `sclk_i` rising edge. In falling mode it changes on the following falling edge.
- R5: Control 01 writes the code into the addressed staging register and leaves every output register unchanged.
- R6: Control 11 writes the code into both the addressed staging register and the addressed output register.
- R7: Control 00 with address 01 writes the code into all four output registers. Code 00 therefore zeroes every output.
- R8: Control 10 copies every staging register into its output register. Address 00 does only that. Address 10 also selects falling mode, and address 11 also selects rising mode.
- R9: Control 00 with address 00, and the unused codes (00 with address 10 or 11, and 10 with address 01), change no register.
- R10: While `clrn_i` is low, all staging and output registers are zero. This takes priority over a command that completes in the same cycle.
- R11: While `ldn_i` is low, every output register follows its staging register. This includes a staging value written during that time.
- R12: After reset, all registers are zero, `sdo_o` is 0, the shift register is clear, and the block is in rising mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk_i | input | 1 | Serial clock |
| csn_i | input | 1 | Serial select, active low |
| sdi_i | input | 1 | Serial data in |
| clrn_i | input | 1 | Clear all registers, active low |
| ldn_i | input | 1 | Copy staging to output registers, active low, level |
| sdo_o | output | 1 | Serial data out, delayed by 12 serial clocks |
| dac_code_o | output | NCH*DW | Output register codes; channel i sits at bits [i*DW +: DW] |

## Verification
Some behaviours are checked by assertions on every cycle. These are: a serial rising edge inside the select window shifts the sampled data bit in; the data output holds steady while select is high; a clear leaves every output at zero; a staging-only load leaves the outputs alone; an update-all command puts the received code on every channel; and the falling-mode command switches the output edge. Other behaviours can only be shown by the bench's scenarios. These are the twelve-clock delay of the data output and the edge it moves on in each mode, dropping the leading bits of a long frame, the command sequences that build and then copy staging values, the load input picking up a value written while it is held low, and the clear input also emptying the staging registers.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

  // Control field of a received word
  typedef enum logic [1:0] {
    CTL_GLOBAL_A = 2'b00,
    CTL_STAGE    = 2'b01,
    CTL_GLOBAL_B = 2'b10,
    CTL_BOTH     = 2'b11
  } qdac_ctl_e;

  // Decoded action applied at the end of a frame
  typedef enum logic [2:0] {
    OP_NONE,
    OP_STAGE,
    OP_BOTH,
    OP_BROADCAST,
    OP_COPY,
    OP_COPY_FALL,
    OP_COPY_RISE
  } qdac_op_e;

endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int              W       = 1,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;

endmodule

// File: rtl/qdac_shift.sv
module qdac_shift #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              csn_s,
  input  logic              sdi_s,
  input  logic              mode_rise,
  output logic [WORD_W-1:0] word_o,
  output logic              fire_o,
  output logic              sdo_o
);

  logic              sclk_prev_q;
  logic              csn_prev_q;
  logic [WORD_W-1:0] sh_q;
  logic              out_bit_q;
  logic              sdo_q;
  logic              sclk_rise;
  logic              sclk_fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_prev_q <= 1'b0;
      csn_prev_q  <= 1'b1;
    end else begin
      sclk_prev_q <= sclk_s;
      csn_prev_q  <= csn_s;
    end
  end

  assign sclk_rise = sclk_s & ~sclk_prev_q;
  assign sclk_fall = ~sclk_s & sclk_prev_q;
  assign fire_o    = csn_s & ~csn_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q      <= '0;
      out_bit_q <= 1'b0;
      sdo_q     <= 1'b0;
    end else begin
      if (sclk_rise && !csn_s) begin
        sh_q      <= {sh_q[WORD_W-2:0], sdi_s};
        out_bit_q <= sh_q[WORD_W-1];
        if (mode_rise) sdo_q <= sh_q[WORD_W-1];
      end
      if (sclk_fall && !csn_s && !mode_rise) sdo_q <= out_bit_q;
    end
  end

  assign word_o = sh_q;
  assign sdo_o  = sdo_q;

  // R1
  shift_in_chk: assert property (@(posedge clk) disable iff (rst)
    (sclk_rise && !csn_s) |=> (sh_q[0] == $past(sdi_s)));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    csn_s |=> $stable(sdo_q));

endmodule

// File: rtl/qdac_bank.sv
module qdac_bank
  import qdac_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int DW     = 8,
  parameter int AW     = 2,
  parameter int WORD_W = AW + 2 + DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_act,
  input  logic              ld_act,
  input  logic              fire,
  input  logic [WORD_W-1:0] word_i,
  output logic [NCH*DW-1:0] dac_o,
  output logic              mode_rise_o
);

  logic [AW-1:0] addr;
  qdac_ctl_e     ctl;
  logic [DW-1:0] code;
  qdac_op_e      op;

  assign addr = word_i[WORD_W-1 -: AW];
  assign ctl  = qdac_ctl_e'(word_i[DW+1:DW]);
  assign code = word_i[DW-1:0];

  always_comb begin
    op = OP_NONE;
    case (ctl)
      CTL_STAGE: op = OP_STAGE;
      CTL_BOTH:  op = OP_BOTH;
      CTL_GLOBAL_A: begin
        if (addr == AW'(1)) op = OP_BROADCAST;
      end
      CTL_GLOBAL_B: begin
        if (addr == AW'(0))      op = OP_COPY;
        else if (addr == AW'(2)) op = OP_COPY_FALL;
        else if (addr == AW'(3)) op = OP_COPY_RISE;
      end
      default: op = OP_NONE;
    endcase
  end

  logic mode_rise_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_rise_q <= 1'b1;
    end else if (fire) begin
      if (op == OP_COPY_FALL)      mode_rise_q <= 1'b0;
      else if (op == OP_COPY_RISE) mode_rise_q <= 1'b1;
    end
  end

  assign mode_rise_o = mode_rise_q;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [DW-1:0] stage_q;
    logic [DW-1:0] dac_q;
    logic          sel;

    assign sel = (addr == AW'(i));

    always_ff @(posedge clk) begin
      if (rst || clr_act) begin
        stage_q <= '0;
        dac_q   <= '0;
      end else begin
        if (ld_act) dac_q <= stage_q;
        if (fire) begin
          case (op)
            OP_STAGE: if (sel) stage_q <= code;
            OP_BOTH: if (sel) begin
              stage_q <= code;
              dac_q   <= code;
            end
            OP_BROADCAST: dac_q <= code;
            OP_COPY, OP_COPY_FALL, OP_COPY_RISE: dac_q <= stage_q;
            default: ;
          endcase
        end
      end
    end

    assign dac_o[i*DW +: DW] = dac_q;

    // R7
    broadcast_chk: assert property (@(posedge clk) disable iff (rst)
      (fire && op == OP_BROADCAST && !clr_act) |=> (dac_q == $past(code)));
  end

  // R10
  clear_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr_act |=> (dac_o == '0));

  // R5
  stage_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_STAGE && !ld_act && !clr_act) |=> $stable(dac_o));

  // R8
  fall_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (fire && op == OP_COPY_FALL) |=> !mode_rise_q);

endmodule

// File: rtl/qdac_front.sv
module qdac_front #(
  parameter int NCH = 4,
  parameter int DW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  input  logic              clrn_i,
  input  logic              ldn_i,
  output logic              sdo_o,
  output logic [NCH*DW-1:0] dac_code_o
);

  localparam int AW     = $clog2(NCH);
  localparam int WORD_W = AW + 2 + DW;
  localparam int NPIN   = 5;
  // order: sclk, csn, sdi, clrn, ldn
  localparam logic [NPIN-1:0] PIN_IDLE = 5'b01011;

  logic [NPIN-1:0]   pins_s;
  logic              sclk_s, csn_s, sdi_s, clrn_s, ldn_s;
  logic [WORD_W-1:0] word;
  logic              fire;
  logic              mode_rise;

  qdac_sync #(.W(NPIN), .RST_VAL(PIN_IDLE)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({sclk_i, csn_i, sdi_i, clrn_i, ldn_i}),
    .q_o (pins_s)
  );

  assign {sclk_s, csn_s, sdi_s, clrn_s, ldn_s} = pins_s;

  qdac_shift #(.WORD_W(WORD_W)) u_shift (
    .clk       (clk),
    .rst       (rst),
    .sclk_s    (sclk_s),
    .csn_s     (csn_s),
    .sdi_s     (sdi_s),
    .mode_rise (mode_rise),
    .word_o    (word),
    .fire_o    (fire),
    .sdo_o     (sdo_o)
  );

  qdac_bank #(.NCH(NCH), .DW(DW), .AW(AW), .WORD_W(WORD_W)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .clr_act     (~clrn_s),
    .ld_act      (~ldn_s),
    .fire        (fire),
    .word_i      (word),
    .dac_o       (dac_code_o),
    .mode_rise_o (mode_rise)
  );

endmodule

// File: tb/tb_qdac_front.sv
module tb_qdac_front;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        sclk = 1'b0, csn = 1'b1, sdi = 1'b0, clrn = 1'b1, ldn = 1'b1;
  logic        sdo;
  logic [31:0] dac;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [16:0] hi_s, lo_s;

  always #10 clk = ~clk;

  qdac_front dut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .clrn_i(clrn), .ldn_i(ldn), .sdo_o(sdo), .dac_code_o(dac)
  );

  // {word, expected dac {D,C,B,A}}
  localparam logic [43:0] VEC [10] = '{
    {12'h15A, 32'h00000000},
    {12'h53C, 32'h00000000},
    {12'hB77, 32'h00770000},
    {12'h2FF, 32'h00773C5A},
    {12'h0EE, 32'h00773C5A},
    {12'hC99, 32'h00773C5A},
    {12'hF12, 32'h12773C5A},
    {12'h4C3, 32'hC3C3C3C3},
    {12'h200, 32'h12773C5A},
    {12'h400, 32'h00000000}
  };

  function automatic string vec_tag(int i);
    case (i)
      0: return "R1 R5";
      1: return "R5";
      2: return "R6";
      3: return "R8";
      4: return "R9";
      5: return "R9";
      6: return "R6";
      7: return "R7";
      8: return "R8";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(logic [15:0] w, int n);
    csn = 1'b0;
    wclk(4);
    for (int j = 1; j <= n; j++) begin
      sdi = w[n-j];
      wclk(4);
      lo_s[j-1] = sdo;
      sclk = 1'b1;
      wclk(4);
      hi_s[j] = sdo;
      sclk = 1'b0;
    end
    wclk(4);
    lo_s[n] = sdo;
    csn = 1'b1;
    wclk(10);
  endtask

  function automatic logic [11:0] hi_word();
    logic [11:0] r;
    for (int k = 1; k <= 12; k++) r[12-k] = hi_s[k];
    return r;
  endfunction

  function automatic logic [11:0] lo_word();
    logic [11:0] r;
    for (int k = 1; k <= 12; k++) r[12-k] = lo_s[k];
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R12 watchdog actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic       prev;
    logic       held;
    logic [10:0] hw0, ew0;
    wclk(5);
    rst = 1'b0;
    wclk(3);
    // R12 reset state
    chk("R12", dac, 32'h0, "codes after reset");
    chk("R12", {31'b0, sdo}, 32'h0, "sdo after reset");

    for (int i = 0; i < 10; i++) begin
      frame({4'h0, VEC[i][43:32]}, 12);
      chk(vec_tag(i), dac, VEC[i][31:0], $sformatf("table step %0d", i));
    end

    // R2 sixteen-bit frame, leading nibble dropped
    frame(16'hF3AB, 16);
    chk("R2", dac, 32'h000000AB, "long frame keeps last 12 bits");

    // R6 load channel D both registers
    frame(16'h0F34, 12);
    chk("R6", dac, 32'h340000AB, "load both channel D");

    // R3 serial clock ignored while select high
    prev = sdo;
    held = 1'b1;
    for (int t = 0; t < 5; t++) begin
      sdi = 1'b1;
      sclk = 1'b1; wclk(4);
      if (sdo !== prev) held = 1'b0;
      sclk = 1'b0; wclk(4);
      if (sdo !== prev) held = 1'b0;
    end
    sdi = 1'b0;
    chk("R3", {31'b0, held}, 32'h1, "sdo held while select high");

    // R4 rising mode: NOP frame carries out the previous word
    frame(16'h00C5, 12);
    chk("R4", {20'b0, hi_word()}, 32'h00000F34, "rising mode delayed output");
    chk("R9", dac, 32'h340000AB, "nop leaves codes");

    // R5 staging only for channel D
    frame(16'h0D66, 12);
    chk("R5", dac, 32'h340000AB, "staging write leaves outputs");

    // R8 falling mode command also copies
    frame(16'h0A5C, 12);
    chk("R8", dac, 32'h66773CAB, "falling-mode command copies");

    // R4 falling mode timing
    frame(16'h0000, 12);
    chk("R4", {20'b0, lo_word()}, 32'h00000A5C, "falling mode value after fall");
    hw0 = '0; ew0 = '0;
    for (int k = 2; k <= 12; k++) begin
      hw0[12-k] = hi_s[k];
      ew0[12-k] = VEC[0][43:32] == 12'h0 ? 1'b0 : 1'b0;
    end
    ew0 = 11'h52E; // bits of 0xA5C shifted one later: 1010_0101_110
    chk("R4", {21'b0, hw0}, {21'b0, ew0}, "falling mode holds through high phase");

    // R8 back to rising mode
    frame(16'h0E00, 12);
    frame(16'h00C5, 12);
    chk("R8", {20'b0, hi_word()}, 32'h00000E00, "rising mode restored");

    // R11 load input held low while staging write lands
    ldn = 1'b0;
    frame(16'h05C8, 12);
    chk("R11", dac, 32'h6677C8AB, "staging reaches output under load");
    ldn = 1'b1;
    wclk(6);
    frame(16'h09E1, 12);
    chk("R5", dac, 32'h6677C8AB, "staging channel C only");
    ldn = 1'b0;
    wclk(4);
    ldn = 1'b1;
    wclk(8);
    chk("R11", dac, 32'h66E1C8AB, "load pulse copies staging");

    // R10 clear wins over a completing command
    csn = 1'b0;
    wclk(4);
    for (int j = 11; j >= 0; j--) begin
      sdi = 12'h3AB >> j;
      wclk(4); sclk = 1'b1; wclk(4); sclk = 1'b0;
    end
    wclk(4);
    clrn = 1'b0;
    csn = 1'b1;
    wclk(10);
    clrn = 1'b1;
    wclk(6);
    chk("R10", dac, 32'h0, "clear beats command");
    frame(16'h0200, 12);
    chk("R10", dac, 32'h0, "clear emptied staging");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule